// File: doc/BRIEF.md
# Line Interface Control and Loopback Selector

This block is the digital control core of a T1/E1 line interface. It takes the equalizer code, the jitter-attenuator placement code and the loopback code from control pins. It can take them continuously, or capture them through a chip-select latch. It then decides where clock and dual-rail data flow between four sources: the terminal's transmit side, the recovered receive side, the jitter-attenuator (smoothed) side and a free-running reference. The routing feeds two destinations: the receive outputs toward the terminal and the line driver. It also generates the all-ones alarm indication signal (AIS) and turns the dual-rail NRZ stream into tip and ring pulse enables.

All clocks of the interface arrive as single-cycle strobes in one system clock domain: a transmit strobe, a recovered strobe, a reference strobe and a smoothed strobe. Each strobe comes with its positive and negative data rails. The receive clock output is likewise a strobe. The analog pulse shaper and the clock recovery loop sit outside this block.

Top module: `lif_core`

## Requirements
- R1: While `cs_n_i` is low, the control pins are captured on every clock edge, so `eq_code_o` equals the `eq_sel_i` value of the previous cycle.
- R2: While `cs_n_i` is high, the captured controls hold, and changes on `eq_sel_i`, `ja_sel_i` and `lb_sel_i` have no effect on `eq_code_o` or on the routing.
- R3: After reset, the captured controls are all zero (no loopback, attenuator bypassed, equalizer code 0), and every output is low.
- R4: With loopback code `lb_sel_i`=00 (normal), the receive outputs carry the recovered strobe and rails one cycle later.
- R5: Line encoding: a strobe with only the positive rail set pulses `tip_en_o`, and a strobe with only the negative rail set pulses `ring_en_o`. A strobe with neither rail set drives neither output, and so does a strobe with both rails set. Each pulse lasts exactly the one cycle after the strobe, and the two outputs are never high together.
- R6: When `ais_req_i` is high and the loopback is not remote, transmit data is ignored. Each reference strobe then produces one mark, with polarity alternating. The first mark after AIS starts goes on tip.
- R7: `ais_req_i` bypasses the chip-select latch and takes effect one cycle later even while `cs_n_i` is high.
- R8: Loopback code 10 (remote) sends the recovered strobe and rails to the line, ignoring transmit inputs and `ais_req_i`. The receive outputs still carry the recovered stream.
- R9: Loopback code 01 (digital local) puts the transmit strobe and rails on the receive outputs. The line keeps transmitting, including AIS when requested.
- R10: Loopback code 11 (local) with attenuator code `ja_sel_i`=01 (transmit path) puts the smoothed strobe and rails on the receive outputs, while the line carries the smoothed stream or AIS.
- R11: Loopback code 11 with any attenuator code other than 01 leaves the receive outputs on the recovered stream and raises `cfg_fault_o`.
- R12: With attenuator code 01 and no AIS, the line is fed by the smoothed stream; with any other code it is fed by the transmit stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Chip select, low = capture control pins |
| eq_sel_i | input | 3 | Equalizer / rate code |
| ja_sel_i | input | 2 | Attenuator placement: 00 bypass, 01 transmit, 10 receive, 11 test |
| lb_sel_i | input | 2 | Loopback: 00 none, 01 digital local, 10 remote, 11 local |
| ais_req_i | input | 1 | All-ones alarm request, not latched |
| tx_stb_i | input | 1 | Transmit clock strobe |
| tx_pos_i | input | 1 | Transmit positive rail |
| tx_neg_i | input | 1 | Transmit negative rail |
| rec_stb_i | input | 1 | Recovered clock strobe |
| rec_pos_i | input | 1 | Recovered positive rail |
| rec_neg_i | input | 1 | Recovered negative rail |
| ref_stb_i | input | 1 | Reference clock strobe |
| sm_stb_i | input | 1 | Smoothed clock strobe |
| sm_pos_i | input | 1 | Smoothed positive rail |
| sm_neg_i | input | 1 | Smoothed negative rail |
| rx_stb_o | output | 1 | Receive clock strobe to terminal |
| rx_pos_o | output | 1 | Receive positive rail |
| rx_neg_o | output | 1 | Receive negative rail |
| tip_en_o | output | 1 | Tip pulse enable |
| ring_en_o | output | 1 | Ring pulse enable |
| eq_code_o | output | 3 | Captured equalizer code |
| cfg_fault_o | output | 1 | Local loopback selected without attenuator in transmit path |

## Verification
Data strobes, rails and the AIS request reach the receive and line outputs one cycle after they are applied. A control pin change reaches `eq_code_o` one cycle later and the routing and `cfg_fault_o` two cycles later, because of the capture register. The bench model evaluates each rising edge from the inputs it sees and from its own copy of the captured controls and AIS polarity, and compares at the following falling edge. Directed sequences cover the hold with chip select high, AIS under the closed latch and the reset state.

// File: rtl/lif_pkg.sv
package lif_pkg;
  localparam int EQ_W = 3;

  typedef enum logic [1:0] {
    LB_NONE    = 2'b00,
    LB_DIGITAL = 2'b01,
    LB_REMOTE  = 2'b10,
    LB_LOCAL   = 2'b11
  } lb_e;

  typedef enum logic [1:0] {
    JA_BYPASS = 2'b00,
    JA_TX     = 2'b01,
    JA_RX     = 2'b10,
    JA_TEST   = 2'b11
  } ja_e;

  typedef struct packed {
    logic [EQ_W-1:0] eq;
    ja_e             ja;
    lb_e             lb;
  } cfg_t;

  typedef struct packed {
    logic stb;
    logic pos;
    logic neg;
  } lane_t;

  localparam lane_t LANE_IDLE = '0;
endpackage

// File: rtl/lif_rst_sync.sv
module lif_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb pipe_d = {pipe_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= pipe_d;
  end

  assign rst_no = pipe_q[STAGES-1];
endmodule

// File: rtl/lif_ctrl_latch.sv
module lif_ctrl_latch
  import lif_pkg::*;
(
  input  logic            clk,
  input  logic            rst_ni,
  input  logic            cs_n_i,
  input  logic [EQ_W-1:0] eq_sel_i,
  input  logic [1:0]      ja_sel_i,
  input  logic [1:0]      lb_sel_i,
  output cfg_t            cfg_o
);
  cfg_t cfg_q;
  cfg_t cfg_d;
  cfg_t pins;
  logic load_en;

  always_comb begin
    pins.eq = eq_sel_i;
    pins.ja = ja_e'(ja_sel_i);
    pins.lb = lb_e'(lb_sel_i);
    load_en = ~cs_n_i;
    cfg_d   = load_en ? pins : cfg_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg_d;
  end

  assign cfg_o = cfg_q;

  // R2
  hold_when_deselected_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    cs_n_i |=> $stable(cfg_q));

  // R1
  capture_when_selected_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !cs_n_i |=> (cfg_q.eq == $past(eq_sel_i)));
endmodule

// File: rtl/lif_path_sel.sv
module lif_path_sel
  import lif_pkg::*;
(
  input  logic  clk,
  input  logic  rst_ni,
  input  cfg_t  cfg_i,
  input  logic  ais_req_i,
  input  lane_t tx_i,
  input  lane_t rec_i,
  input  lane_t sm_i,
  input  logic  ref_stb_i,
  output lane_t line_o,
  output logic  ais_act_o,
  output lane_t rx_o,
  output logic  fault_o
);
  logic  remote;
  logic  ja_tx;
  lane_t rx_d;
  lane_t rx_q;
  logic  fault_d;
  logic  fault_q;

  always_comb begin
    remote    = (cfg_i.lb == LB_REMOTE);
    ja_tx     = (cfg_i.ja == JA_TX);
    ais_act_o = ais_req_i & ~remote;

    if (remote)         line_o = rec_i;
    else if (ais_act_o) line_o = '{stb: ref_stb_i, pos: 1'b0, neg: 1'b0};
    else if (ja_tx)     line_o = sm_i;
    else                line_o = tx_i;

    unique case (cfg_i.lb)
      LB_DIGITAL: rx_d = tx_i;
      LB_LOCAL:   rx_d = ja_tx ? sm_i : rec_i;
      default:    rx_d = rec_i;
    endcase

    fault_d = (cfg_i.lb == LB_LOCAL) & ~ja_tx;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q    <= LANE_IDLE;
      fault_q <= 1'b0;
    end else begin
      rx_q    <= rx_d;
      fault_q <= fault_d;
    end
  end

  assign rx_o    = rx_q;
  assign fault_o = fault_q;

  // R9
  digital_loop_rx_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (cfg_i.lb == LB_DIGITAL) |=> (rx_q == $past(tx_i)));

  // R11
  local_fault_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (cfg_i.lb == LB_LOCAL && cfg_i.ja != JA_TX) |=> (fault_q && rx_q == $past(rec_i)));
endmodule

// File: rtl/lif_line_enc.sv
module lif_line_enc
  import lif_pkg::*;
(
  input  logic  clk,
  input  logic  rst_ni,
  input  lane_t line_i,
  input  logic  ais_act_i,
  output logic  tip_o,
  output logic  ring_o
);
  logic phase_q;
  logic phase_d;
  logic tip_d;
  logic ring_d;
  logic tip_q;
  logic ring_q;

  always_comb begin
    if (ais_act_i) begin
      tip_d   = line_i.stb & ~phase_q;
      ring_d  = line_i.stb &  phase_q;
      phase_d = line_i.stb ? ~phase_q : phase_q;
    end else begin
      tip_d   = line_i.stb & line_i.pos & ~line_i.neg;
      ring_d  = line_i.stb & line_i.neg & ~line_i.pos;
      phase_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      tip_q   <= 1'b0;
      ring_q  <= 1'b0;
      phase_q <= 1'b0;
    end else begin
      tip_q   <= tip_d;
      ring_q  <= ring_d;
      phase_q <= phase_d;
    end
  end

  assign tip_o  = tip_q;
  assign ring_o = ring_q;

  // R5
  tip_ring_excl_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !(tip_q && ring_q));

  // R5
  pulse_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !line_i.stb |=> !(tip_q || ring_q));
endmodule

// File: rtl/lif_core.sv
module lif_core
  import lif_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_n_i,
  input  logic [EQ_W-1:0] eq_sel_i,
  input  logic [1:0]      ja_sel_i,
  input  logic [1:0]      lb_sel_i,
  input  logic            ais_req_i,
  input  logic            tx_stb_i,
  input  logic            tx_pos_i,
  input  logic            tx_neg_i,
  input  logic            rec_stb_i,
  input  logic            rec_pos_i,
  input  logic            rec_neg_i,
  input  logic            ref_stb_i,
  input  logic            sm_stb_i,
  input  logic            sm_pos_i,
  input  logic            sm_neg_i,
  output logic            rx_stb_o,
  output logic            rx_pos_o,
  output logic            rx_neg_o,
  output logic            tip_en_o,
  output logic            ring_en_o,
  output logic [EQ_W-1:0] eq_code_o,
  output logic            cfg_fault_o
);
  localparam int RST_STAGES = 2;

  logic  rst_sync_n;
  cfg_t  cfg;
  lane_t tx_l;
  lane_t rec_l;
  lane_t sm_l;
  lane_t line_l;
  lane_t rx_l;
  logic  ais_act;

  always_comb begin
    tx_l  = '{stb: tx_stb_i,  pos: tx_pos_i,  neg: tx_neg_i};
    rec_l = '{stb: rec_stb_i, pos: rec_pos_i, neg: rec_neg_i};
    sm_l  = '{stb: sm_stb_i,  pos: sm_pos_i,  neg: sm_neg_i};
  end

  lif_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_sync_n)
  );

  lif_ctrl_latch u_ctrl (
    .clk      (clk),
    .rst_ni   (rst_sync_n),
    .cs_n_i   (cs_n_i),
    .eq_sel_i (eq_sel_i),
    .ja_sel_i (ja_sel_i),
    .lb_sel_i (lb_sel_i),
    .cfg_o    (cfg)
  );

  lif_path_sel u_path (
    .clk       (clk),
    .rst_ni    (rst_sync_n),
    .cfg_i     (cfg),
    .ais_req_i (ais_req_i),
    .tx_i      (tx_l),
    .rec_i     (rec_l),
    .sm_i      (sm_l),
    .ref_stb_i (ref_stb_i),
    .line_o    (line_l),
    .ais_act_o (ais_act),
    .rx_o      (rx_l),
    .fault_o   (cfg_fault_o)
  );

  lif_line_enc u_enc (
    .clk       (clk),
    .rst_ni    (rst_sync_n),
    .line_i    (line_l),
    .ais_act_i (ais_act),
    .tip_o     (tip_en_o),
    .ring_o    (ring_en_o)
  );

  assign rx_stb_o  = rx_l.stb;
  assign rx_pos_o  = rx_l.pos;
  assign rx_neg_o  = rx_l.neg;
  assign eq_code_o = cfg.eq;

  // R6
  ais_mark_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ais_req_i && cfg.lb != LB_REMOTE && ref_stb_i) |=> (tip_en_o ^ ring_en_o));

  // R8
  remote_tip_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg.lb == LB_REMOTE && rec_stb_i && rec_pos_i && !rec_neg_i) |=> (tip_en_o && !ring_en_o));
endmodule

// File: tb/lif_core_tb.sv
`timescale 1ns/1ps
module lif_core_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic [2:0] eq_sel = '0;
  logic [1:0] ja_sel = '0;
  logic [1:0] lb_sel = '0;
  logic ais_req = 1'b0;
  logic tx_stb = 0, tx_pos = 0, tx_neg = 0;
  logic rec_stb = 0, rec_pos = 0, rec_neg = 0;
  logic ref_stb = 0;
  logic sm_stb = 0, sm_pos = 0, sm_neg = 0;
  logic rx_stb, rx_pos, rx_neg, tip_en, ring_en, cfg_fault;
  logic [2:0] eq_code;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  lif_core u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .eq_sel_i(eq_sel),
    .ja_sel_i(ja_sel), .lb_sel_i(lb_sel), .ais_req_i(ais_req),
    .tx_stb_i(tx_stb), .tx_pos_i(tx_pos), .tx_neg_i(tx_neg),
    .rec_stb_i(rec_stb), .rec_pos_i(rec_pos), .rec_neg_i(rec_neg),
    .ref_stb_i(ref_stb), .sm_stb_i(sm_stb), .sm_pos_i(sm_pos), .sm_neg_i(sm_neg),
    .rx_stb_o(rx_stb), .rx_pos_o(rx_pos), .rx_neg_o(rx_neg),
    .tip_en_o(tip_en), .ring_en_o(ring_en), .eq_code_o(eq_code),
    .cfg_fault_o(cfg_fault)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model state (built from the requirements)
  logic       model_on = 1'b0;
  logic       exp_valid = 1'b0;
  logic [2:0] m_eq = '0;
  logic [1:0] m_ja = '0;
  logic [1:0] m_lb = '0;
  logic       m_ph = 1'b0;
  logic [2:0] e_rx;
  logic       e_tip, e_ring, e_fault;
  logic [2:0] e_eq;
  string      t_rx, t_line;

  function automatic logic [1:0] enc(input logic s, input logic p, input logic n);
    return {s & p & ~n, s & n & ~p};
  endfunction

  always @(posedge clk) begin
    if (model_on) begin
      logic ais_act;
      logic [1:0] tr;
      ais_act = ais_req && (m_lb != 2'b10);
      // receive path
      if (m_lb == 2'b01) begin e_rx = {tx_stb, tx_pos, tx_neg}; t_rx = "R9"; end
      else if (m_lb == 2'b11 && m_ja == 2'b01) begin e_rx = {sm_stb, sm_pos, sm_neg}; t_rx = "R10"; end
      else if (m_lb == 2'b11) begin e_rx = {rec_stb, rec_pos, rec_neg}; t_rx = "R11"; end
      else if (m_lb == 2'b10) begin e_rx = {rec_stb, rec_pos, rec_neg}; t_rx = "R8"; end
      else begin e_rx = {rec_stb, rec_pos, rec_neg}; t_rx = "R4"; end
      // line path
      if (m_lb == 2'b10) begin tr = enc(rec_stb, rec_pos, rec_neg); t_line = "R8"; m_ph = 1'b0; end
      else if (ais_act) begin
        tr = {ref_stb & ~m_ph, ref_stb & m_ph};
        t_line = cs_n ? "R7" : "R6";
        if (ref_stb) m_ph = ~m_ph;
      end
      else if (m_ja == 2'b01) begin tr = enc(sm_stb, sm_pos, sm_neg); t_line = "R12"; m_ph = 1'b0; end
      else begin tr = enc(tx_stb, tx_pos, tx_neg); t_line = "R5"; m_ph = 1'b0; end
      {e_tip, e_ring} = tr;
      e_fault = (m_lb == 2'b11) && (m_ja != 2'b01);
      // control capture
      if (!cs_n) begin m_eq = eq_sel; m_ja = ja_sel; m_lb = lb_sel; end
      e_eq = m_eq;
      exp_valid <= 1'b1;
    end
  end

  always @(negedge clk) begin
    if (exp_valid && model_on) begin
      chk(t_rx, 8'({rx_stb, rx_pos, rx_neg}), 8'(e_rx));
      chk(t_line, 8'({tip_en, ring_en}), 8'({e_tip, e_ring}));
      chk(e_fault ? "R11" : "R10", 8'(cfg_fault), 8'(e_fault));
      chk(cs_n ? "R2" : "R1", 8'(eq_code), 8'(e_eq));
    end
  end

  task automatic rand_data();
    tx_stb  = ($urandom % 3) == 0; tx_pos = $urandom % 2; tx_neg = $urandom % 2;
    rec_stb = ($urandom % 3) == 0; rec_pos = $urandom % 2; rec_neg = $urandom % 2;
    sm_stb  = ($urandom % 3) == 0; sm_pos = $urandom % 2; sm_neg = $urandom % 2;
    ref_stb = ($urandom % 2) == 0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #400000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [2:0] held;
    void'($urandom(32'd7331));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R3: reset state
    chk("R3", 8'({rx_stb, rx_pos, rx_neg, tip_en, ring_en, cfg_fault}), 8'h00);
    chk("R3", 8'(eq_code), 8'h00);
    model_on = 1'b1;

    // R1 then R2: capture code 5, then deselect and wiggle pins
    cs_n = 1'b0; eq_sel = 3'd5; lb_sel = 2'b00; ja_sel = 2'b00;
    @(negedge clk);
    cs_n = 1'b1; eq_sel = 3'd2; lb_sel = 2'b01; ja_sel = 2'b01;
    held = 3'd5;
    for (int i = 0; i < 4; i++) begin
      rand_data();
      @(negedge clk);
    end
    chk("R2", 8'(eq_code), 8'(held));

    // R7: AIS with latch closed, dense reference strobes
    ais_req = 1'b1;
    for (int i = 0; i < 8; i++) begin
      rand_data(); ref_stb = 1'b1;
      @(negedge clk);
    end
    ais_req = 1'b0;

    // R5: both rails set gives no pulse
    tx_stb = 1; tx_pos = 1; tx_neg = 1; ref_stb = 0;
    @(negedge clk);
    tx_stb = 0;
    @(negedge clk);

    // R10: local loopback with attenuator on transmit path, plus AIS
    cs_n = 1'b0; lb_sel = 2'b11; ja_sel = 2'b01;
    @(negedge clk);
    cs_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      rand_data(); ais_req = (i > 2);
      @(negedge clk);
    end
    ais_req = 1'b0;

    // R8: remote loopback with AIS requested
    cs_n = 1'b0; lb_sel = 2'b10; ja_sel = 2'b00;
    @(negedge clk);
    cs_n = 1'b1; ais_req = 1'b1;
    for (int i = 0; i < 6; i++) begin
      rand_data();
      @(negedge clk);
    end
    ais_req = 1'b0;

    // Constrained random mix
    for (int i = 0; i < 4000; i++) begin
      rand_data();
      if (($urandom % 8) == 0) begin
        cs_n   = ($urandom % 4) == 0;
        eq_sel = 3'($urandom);
        ja_sel = 2'($urandom);
        lb_sel = 2'($urandom);
      end
      if (($urandom % 16) == 0) ais_req = ~ais_req;
      @(negedge clk);
    end
    @(negedge clk);
    finish_run();
  end
endmodule